// File: doc/BRIEF.md
# Indirect Descriptor SRAM Access Window

This block puts a small register window on a simple host register bus. The host reaches a private 256-byte descriptor SRAM through that window instead of through a direct memory map. The window has a control register, a pair of offset registers and four data registers. A byte is written to the SRAM when the host writes the first data register. A byte is fetched from the SRAM when the host writes the control register with its start bit set.

The control register also holds three other settings. An enable bit must be set for any access. A two-bit target field picks what the window talks to, and only the code 01 reaches the SRAM. An auto-increment bit makes the offset step forward by one after every SRAM access, so that a host can stream consecutive bytes. Any other target code gives no access, and such writes are dropped.

The register bus uses single-cycle strobes. Read data is registered and appears in the cycle after the read strobe.

Top module: `sram_window`

## Requirements
- R1: After reset every window register reads as zero: control (0x48), offset (0x49), upper offset (0x4A) and data (0x4B to 0x4E).
- R2: The control register at 0x48 stores bit 0 (enable), bit 2 (auto-increment) and bits [4:3] (target) and reads them back. Bit 1 (read start) always reads back as 0.
- R3: When enable is 1 and target is 01, a bus write to 0x4B stores the byte into the SRAM at the current offset, which is held in 0x49, in that same cycle.
- R4: A control write that has bit 0 = 1, bits [4:3] = 01 and bit 1 = 1 fetches the SRAM byte at the current offset into 0x4B on the next clock edge. A read strobe issued from the cycle after that edge onward returns the byte.
- R5: With auto-increment set, each SRAM write through 0x4B advances the offset by one, and the offset wraps from 0xFF to 0x00.
- R6: With auto-increment set, each SRAM fetch advances the offset by one after the fetch, with the same wrap.
- R7: With auto-increment clear, SRAM accesses leave the offset unchanged.
- R8: Writes to 0x4B while enable is 0 or target is not 01 leave the SRAM unchanged. A control write with bit 1 set but enable 0 or target not 01 fetches nothing, so 0x4B keeps its value.
- R9: Writes to 0x4C through 0x4E are ignored, and reads of those addresses return 0.
- R10: Bus read data is registered and is valid in the cycle after the read strobe.
- R11: The upper offset register at 0x4A stores and reads back a byte and has no effect on the SRAM offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | DW | Write data |
| bus_we | input | 1 | Write strobe, one cycle |
| bus_re | input | 1 | Read strobe, one cycle |
| bus_rdata | output | DW | Registered read data |

## Verification
A register write takes effect at the clock edge that samples the write strobe. A read strobe delivers its data at the next edge, so the bench drives strobes on falling edges and samples read data on the falling edge that follows. A fetch has one more register stage: the control write arms it at one edge and the data register is loaded at the next. For that reason the bench leaves one idle cycle after a read-start control write before it reads 0x4B. The checks that offsets and targets are ignored are made by reading the byte back through a correctly selected fetch.

// File: rtl/sram_window.sv
module sram_window #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [7:0] BASE = 8'h48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata
);
  localparam int DEPTH = 1 << AW;
  localparam logic [7:0] A_CTRL = BASE;
  localparam logic [7:0] A_OFS  = BASE + 8'd1;
  localparam logic [7:0] A_OFSH = BASE + 8'd2;
  localparam logic [7:0] A_DAT0 = BASE + 8'd3;

  logic          en, ai, rd_pend;
  logic [1:0]    tgt;
  logic [AW-1:0] ofs;
  logic [DW-1:0] ofs_hi, dat0, rmux;
  logic [DW-1:0] mem [DEPTH];

  wire sel      = en && (tgt == 2'b01);
  wire wsel_new = bus_wdata[0] && (bus_wdata[4:3] == 2'b01);
  wire hit_ctrl = bus_we && (bus_addr == A_CTRL);
  wire hit_ofs  = bus_we && (bus_addr == A_OFS);
  wire hit_ofsh = bus_we && (bus_addr == A_OFSH);
  wire hit_dat0 = bus_we && (bus_addr == A_DAT0);
  wire do_wr    = hit_dat0 && sel;
  wire step     = ai && (do_wr || rd_pend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; ai <= 1'b0; tgt <= '0; rd_pend <= 1'b0;
      ofs <= '0; ofs_hi <= '0; dat0 <= '0; bus_rdata <= '0;
    end else begin
      if (hit_ctrl) begin
        en  <= bus_wdata[0];
        ai  <= bus_wdata[2];
        tgt <= bus_wdata[4:3];
      end
      rd_pend <= hit_ctrl && bus_wdata[1] && wsel_new;
      if (hit_ofs) ofs <= bus_wdata[AW-1:0];
      else if (step) ofs <= ofs + 1'b1;
      if (hit_ofsh) ofs_hi <= bus_wdata;
      if (rd_pend) dat0 <= mem[ofs];
      else if (hit_dat0) dat0 <= bus_wdata;
      if (bus_re) bus_rdata <= rmux;
    end
  end

  always_ff @(posedge clk)
    if (do_wr) mem[ofs] <= bus_wdata;

  always_comb begin
    rmux = '0;
    case (bus_addr)
      A_CTRL: rmux[4:0] = {tgt, ai, 1'b0, en};
      A_OFS:  rmux[AW-1:0] = ofs;
      A_OFSH: rmux = ofs_hi;
      A_DAT0: rmux = dat0;
      default: rmux = '0;
    endcase
  end
endmodule

module sram_window_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [7:0] BASE = 8'h48
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    bus_addr,
  input logic          bus_we,
  input logic          bus_re,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          en,
  input logic          ai,
  input logic [1:0]    tgt,
  input logic [AW-1:0] ofs,
  input logic          rd_pend
);
  localparam logic [7:0] C_OFS = BASE + 8'd1;
  localparam logic [7:0] C_D0  = BASE + 8'd3;
  localparam logic [7:0] C_D1  = BASE + 8'd4;
  localparam logic [7:0] C_D3  = BASE + 8'd6;

  logic [AW-1:0] nxt;
  assign nxt = ofs + 1'b1;
  wire ofs_wr = bus_we && (bus_addr == C_OFS);

  AST_START_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == BASE) |=> !bus_rdata[1]); // R2
  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C_D0 && en && tgt == 2'b01 && ai && !rd_pend) |=> ofs == $past(nxt)); // R5
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && ai && !ofs_wr) |=> ofs == $past(nxt)); // R6
  AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ai && !ofs_wr) |=> $stable(ofs)); // R7
  AST_NOSEL_NOFETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == BASE && !(bus_wdata[0] && bus_wdata[4:3] == 2'b01)) |=> !rd_pend); // R8
  AST_UPPER_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr >= C_D1 && bus_addr <= C_D3) |=> bus_rdata == '0); // R9
endmodule

bind sram_window sram_window_chk #(.AW(AW), .DW(DW), .BASE(BASE)) chk (.*);

// File: tb/sram_window_test.sv
module sram_window_test;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sram_window uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                   .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata));

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0;
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic fetch(input logic [7:0] ctrl);
    wr(8'h48, ctrl); idle();
  endtask

  task automatic t_reset();
    for (int a = 8'h48; a <= 8'h4E; a++) rd(8'(a), 8'h00, "R1 R10");
  endtask

  task automatic t_ctrl();
    wr(8'h48, 8'h1F); rd(8'h48, 8'h1D, "R2");
    wr(8'h48, 8'h0A); rd(8'h48, 8'h08, "R2");
  endtask

  task automatic t_write_read();
    wr(8'h48, 8'h09);
    wr(8'h49, 8'h10); wr(8'h4B, 8'hA5);
    wr(8'h49, 8'h11); wr(8'h4B, 8'h3C);
    rd(8'h49, 8'h11, "R7 write");
    wr(8'h49, 8'h10); fetch(8'h0B); rd(8'h4B, 8'hA5, "R3 R4");
    rd(8'h49, 8'h10, "R7 fetch");
    wr(8'h49, 8'h11); fetch(8'h0B); rd(8'h4B, 8'h3C, "R3 R4");
  endtask

  task automatic t_ai_write();
    wr(8'h48, 8'h0D); wr(8'h49, 8'hFE);
    wr(8'h4B, 8'h11); wr(8'h4B, 8'h22); wr(8'h4B, 8'h33);
    rd(8'h49, 8'h01, "R5 wrap");
    wr(8'h48, 8'h09);
    wr(8'h49, 8'hFF); fetch(8'h0B); rd(8'h4B, 8'h22, "R5");
    wr(8'h49, 8'h00); fetch(8'h0B); rd(8'h4B, 8'h33, "R5");
    wr(8'h49, 8'hFE); fetch(8'h0B); rd(8'h4B, 8'h11, "R5");
  endtask

  task automatic t_ai_read();
    wr(8'h48, 8'h0D); wr(8'h49, 8'hFE);
    fetch(8'h0F); rd(8'h4B, 8'h11, "R6"); rd(8'h49, 8'hFF, "R6");
    fetch(8'h0F); rd(8'h4B, 8'h22, "R6"); rd(8'h49, 8'h00, "R6 wrap");
  endtask

  task automatic t_ignored();
    wr(8'h48, 8'h19); wr(8'h49, 8'h10); wr(8'h4B, 8'h77);
    wr(8'h48, 8'h08); wr(8'h4B, 8'h66);
    fetch(8'h03); rd(8'h4B, 8'h66, "R8 no fetch");
    fetch(8'h1B); rd(8'h4B, 8'h66, "R8 no fetch");
    rd(8'h49, 8'h10, "R8");
    fetch(8'h0B); rd(8'h4B, 8'hA5, "R8 sram kept");
  endtask

  task automatic t_upper();
    wr(8'h48, 8'h09); wr(8'h49, 8'h20); wr(8'h4B, 8'h5E);
    wr(8'h4C, 8'hFF); wr(8'h4D, 8'hFF); wr(8'h4E, 8'hFF);
    rd(8'h4C, 8'h00, "R9"); rd(8'h4D, 8'h00, "R9"); rd(8'h4E, 8'h00, "R9");
    rd(8'h4B, 8'h5E, "R9 data0 kept");
    fetch(8'h0B); rd(8'h4B, 8'h5E, "R9 sram kept");
  endtask

  task automatic t_ofs_hi();
    wr(8'h4A, 8'h5A); rd(8'h4A, 8'h5A, "R11"); rd(8'h49, 8'h20, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_ctrl(); t_write_read(); t_ai_write();
    t_ai_read(); t_ignored(); t_upper(); t_ofs_hi();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule